// File: doc/BRIEF.md
# Configurable Bitwise Logic Unit

This block is a one-stage logic execution unit for a 32-bit integer datapath. Each operation brings a first operand, a second operand taken either from a register value or from a full-width immediate, a two-bit operation code and two complement controls. The unit complements the chosen operands as asked, then forms the bitwise AND, OR or XOR of the two, or passes the second operand through. Because each input has its own complement control, one encoding also yields AND-NOT, OR-NOT, XNOR and a plain bitwise NOT.

Operations arrive on a valid/ready stream and leave on a second valid/ready stream, together with a 6-bit destination tag that travels with the result. The result sits in one output register. A transfer happens on a rising edge when valid and ready are both high. The unit holds a result and its tag unchanged while the consumer keeps `res_ready` low. While it holds a result and the consumer stalls, it also stops taking new work by dropping `op_ready`. It can take a new operation on the same edge that the held result leaves, so an unstalled stream moves one operation per cycle.

Top module: `lu_logic_unit`

## Requirements
- R1: `op_sel` selects the function: 2'b00 gives AND, 2'b01 gives XOR, 2'b10 gives OR and 2'b11 passes the second operand through.
- R2: When `op_inv_a` is 1, the first operand is bitwise complemented before the function is applied.
- R3: In register form (`op_use_imm` = 0), `op_inv_b` = 1 bitwise complements the second operand before the function is applied. This includes pass-through mode, which then yields the NOT of `op_b`.
- R4: When `op_use_imm` is 1, the second operand is `op_imm`. `op_b` and `op_inv_b` then have no effect on the result.
- R5: An operation is accepted on a rising edge where `op_valid` and `op_ready` are both 1. Its result is on `res_data` with `res_valid` high from that edge on, so it is visible one cycle after acceptance.
- R6: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data` and `res_tag` keep their values on the next edge.
- R7: `op_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1. A new operation can therefore replace a result that leaves on the same edge.
- R8: A synchronous active-high `rst` clears `res_valid`, `res_data` and `res_tag` to 0.
- R9: `res_tag` carries the `op_dst` value of the accepted operation alongside its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present on the input stream |
| op_ready | output | 1 | Unit can accept an operation |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, register form |
| op_imm | input | 32 | Second operand, immediate form |
| op_use_imm | input | 1 | 1 selects `op_imm` as the second operand |
| op_sel | input | 2 | Function code (00 AND, 01 XOR, 10 OR, 11 pass second) |
| op_inv_a | input | 1 | Complement first operand |
| op_inv_b | input | 1 | Complement second operand, register form only |
| op_dst | input | 6 | Destination tag |
| res_valid | output | 1 | Result present on the output stream |
| res_ready | input | 1 | Consumer can take the result |
| res_data | output | 32 | Result value |
| res_tag | output | 6 | Destination tag of the result |

## Verification
A result is due on the first falling edge after the rising edge that accepted it. It then stays due on every following falling edge until a rising edge sees `res_ready` high. The bench models this with a queue holding at most one entry. It compares `res_valid`, `res_data` and `res_tag` against the head of that queue at every falling edge, and checks `op_ready` against the queue and `res_ready` a moment after driving inputs. Pushes and pops are decided from the values that the coming rising edge will sample. Stalled cycles therefore check that the result holds, and an unstalled stream checks the one-cycle timing.

// File: rtl/lu_pkg.sv
package lu_pkg;

  typedef enum logic [1:0] {
    LU_AND  = 2'b00,
    LU_XOR  = 2'b01,
    LU_OR   = 2'b10,
    LU_PASS = 2'b11
  } lu_op_e;

endpackage

// File: rtl/lu_operand_prep.sv
module lu_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] src_imm,
  input  logic         use_imm,
  input  logic         inv_a,
  input  logic         inv_b,
  output logic [W-1:0] opnd_a,
  output logic [W-1:0] opnd_b
);

  // Broadcast the single complement control across the word.
  logic [W-1:0] mask_a;
  logic [W-1:0] mask_b;

  assign mask_a = {W{inv_a}};
  // The immediate form has no second-operand complement.
  assign mask_b = {W{inv_b & ~use_imm}};

  always_comb begin
    opnd_a = src_a ^ mask_a;
    opnd_b = (use_imm ? src_imm : src_b) ^ mask_b;
  end

endmodule

// File: rtl/lu_op_core.sv
module lu_op_core
  import lu_pkg::*;
#(
  parameter int W = 32
) (
  input  lu_op_e       sel,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] z
);

  // One four-input mux per bit lane.
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_comb begin
      unique case (sel)
        LU_AND:  z[i] = x[i] & y[i];
        LU_XOR:  z[i] = x[i] ^ y[i];
        LU_OR:   z[i] = x[i] | y[i];
        default: z[i] = y[i];
      endcase
    end
  end

endmodule

// File: rtl/lu_out_stage.sv
module lu_out_stage #(
  parameter int W     = 32,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [TAG_W-1:0] out_tag
);

  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_tag   <= in_tag;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lu_logic_unit.sv
module lu_logic_unit
  import lu_pkg::*;
#(
  parameter int W     = 32,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [W-1:0]     op_imm,
  input  logic             op_use_imm,
  input  logic [1:0]       op_sel,
  input  logic             op_inv_a,
  input  logic             op_inv_b,
  input  logic [TAG_W-1:0] op_dst,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [W-1:0]     res_data,
  output logic [TAG_W-1:0] res_tag
);

  logic [W-1:0] pa;
  logic [W-1:0] pb;
  logic [W-1:0] fn_out;

  lu_operand_prep #(.W(W)) u_prep (
    .src_a   (op_a),
    .src_b   (op_b),
    .src_imm (op_imm),
    .use_imm (op_use_imm),
    .inv_a   (op_inv_a),
    .inv_b   (op_inv_b),
    .opnd_a  (pa),
    .opnd_b  (pb)
  );

  lu_op_core #(.W(W)) u_core (
    .sel (lu_op_e'(op_sel)),
    .x   (pa),
    .y   (pb),
    .z   (fn_out)
  );

  lu_out_stage #(.W(W), .TAG_W(TAG_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (op_valid),
    .in_ready  (op_ready),
    .in_data   (fn_out),
    .in_tag    (op_dst),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (res_data),
    .out_tag   (res_tag)
  );

endmodule

// File: rtl/lu_logic_unit_chk.sv
module lu_logic_unit_chk #(
  parameter int W     = 32,
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             op_ready,
  input logic [W-1:0]     op_b,
  input logic             op_use_imm,
  input logic [1:0]       op_sel,
  input logic             op_inv_b,
  input logic [TAG_W-1:0] op_dst,
  input logic             res_valid,
  input logic             res_ready,
  input logic [W-1:0]     res_data,
  input logic [TAG_W-1:0] res_tag
);

  p_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=> res_valid);

  p_drain_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready && !op_valid) |=> !res_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_tag)));

  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !op_ready);

  p_free_r7: assert property (@(posedge clk) disable iff (rst)
    (!res_valid || res_ready) |-> op_ready);

  p_not_b_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && !op_use_imm && op_sel == 2'b11 && op_inv_b)
      |=> (res_data == ~$past(op_b)));

  p_pass_b_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && !op_use_imm && op_sel == 2'b11 && !op_inv_b)
      |=> (res_data == $past(op_b)));

  p_tag_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=> (res_tag == $past(op_dst)));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0 && res_tag == '0));

endmodule

bind lu_logic_unit lu_logic_unit_chk #(.W(W), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_b       (op_b),
  .op_use_imm (op_use_imm),
  .op_sel     (op_sel),
  .op_inv_b   (op_inv_b),
  .op_dst     (op_dst),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_data   (res_data),
  .res_tag    (res_tag)
);

// File: tb/test_lu_logic_unit.sv
`timescale 1ns/1ps
module test_lu_logic_unit;

  localparam int W     = 32;
  localparam int TAG_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             op_valid = 1'b0;
  logic             op_ready;
  logic [W-1:0]     op_a = '0;
  logic [W-1:0]     op_b = '0;
  logic [W-1:0]     op_imm = '0;
  logic             op_use_imm = 1'b0;
  logic [1:0]       op_sel = 2'b00;
  logic             op_inv_a = 1'b0;
  logic             op_inv_b = 1'b0;
  logic [TAG_W-1:0] op_dst = '0;
  logic             res_valid;
  logic             res_ready = 1'b1;
  logic [W-1:0]     res_data;
  logic [TAG_W-1:0] res_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0]     q_data[$];
  logic [TAG_W-1:0] q_tag[$];
  string            q_req[$];

  always #10 clk = ~clk;

  lu_logic_unit #(.W(W), .TAG_W(TAG_W)) i_lu_logic_unit (
    .clk(clk), .rst(rst),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .op_imm(op_imm), .op_use_imm(op_use_imm),
    .op_sel(op_sel), .op_inv_a(op_inv_a), .op_inv_b(op_inv_b), .op_dst(op_dst),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_tag(res_tag)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, imm,
      input logic ui, input logic [1:0] s, input logic ia, ib);
    logic [W-1:0] x, y;
    x = ia ? ~a : a;
    if (ui) y = imm;
    else    y = ib ? ~b : b;
    case (s)
      2'd0: return x & y;
      2'd1: return x ^ y;
      2'd2: return x | y;
      default: return y;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: compare outputs with the model, drive the next inputs,
  // check ready, then update the model for the coming rising edge.
  task automatic step(input logic v, input logic [W-1:0] a, b, imm,
      input logic ui, input logic [1:0] s, input logic ia, ib,
      input logic [TAG_W-1:0] d, input logic rdy);
    logic exp_rdy;
    @(negedge clk);
    check("R5", "res_valid", 64'(res_valid), 64'(q_data.size() != 0));
    if (q_data.size() != 0) begin
      check(q_req[0], "res_data", 64'(res_data), 64'(q_data[0]));
      check("R9", "res_tag", 64'(res_tag), 64'(q_tag[0]));
    end
    op_valid = v; op_a = a; op_b = b; op_imm = imm; op_use_imm = ui;
    op_sel = s; op_inv_a = ia; op_inv_b = ib; op_dst = d; res_ready = rdy;
    #1;
    exp_rdy = (q_data.size() == 0) || rdy;
    check(rdy ? "R7" : "R6", "op_ready", 64'(op_ready), 64'(exp_rdy));
    if (q_data.size() != 0 && rdy) begin
      void'(q_data.pop_front()); void'(q_tag.pop_front()); void'(q_req.pop_front());
    end
    if (v && exp_rdy) begin
      q_data.push_back(model(a, b, imm, ui, s, ia, ib));
      q_tag.push_back(d);
      if (ui)      q_req.push_back("R4");
      else if (ib) q_req.push_back("R3");
      else if (ia) q_req.push_back("R2");
      else         q_req.push_back("R1");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "res_valid after reset", 64'(res_valid), 64'd0);
    check("R8", "res_data after reset", 64'(res_data), 64'd0);
    check("R8", "res_tag after reset", 64'(res_tag), 64'd0);
    rst = 1'b0;

    // Sweep: every function, every complement pair, both operand forms.
    for (int ui = 0; ui < 2; ui++)
      for (int s = 0; s < 4; s++)
        for (int inv = 0; inv < 4; inv++)
          step(1'b1, $urandom, $urandom, $urandom, ui[0], s[1:0],
               inv[0], inv[1], 6'($urandom), 1'b1);

    // Directed corners: NOT of op_b, pass of op_imm with op_inv_b ignored.
    step(1'b1, 32'h0, 32'hA5A5_0F0F, 32'h0, 1'b0, 2'b11, 1'b0, 1'b1, 6'd63, 1'b1);
    step(1'b1, 32'hFFFF_FFFF, 32'h1234_5678, 32'hCAFE_F00D, 1'b1, 2'b11, 1'b0, 1'b1, 6'd1, 1'b1);
    step(1'b0, '0, '0, '0, 1'b0, 2'b00, 1'b0, 1'b0, '0, 1'b1);

    // Random traffic with back-pressure.
    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, $urandom, $urandom, $urandom, 1'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom), 6'($urandom),
           ($urandom % 3) != 0);

    // Long stall then drain.
    step(1'b1, 32'h0F0F_0F0F, 32'h00FF_00FF, '0, 1'b0, 2'b01, 1'b1, 1'b0, 6'd42, 1'b0);
    for (int n = 0; n < 5; n++)
      step(1'b1, $urandom, $urandom, $urandom, 1'b0, 2'b00, 1'b0, 1'b0, 6'd7, 1'b0);
    for (int n = 0; n < 4; n++)
      step(1'b0, '0, '0, '0, 1'b0, 2'b00, 1'b0, 1'b0, '0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule